// File: doc/BRIEF.md
# Network Controller Command/Status Register Port

This block is the host-side register file of a network controller. The host reaches it through a 16-bit bus with a single address bit. With the address bit set, the host reads or writes a 2-bit pointer. With the address bit clear, the host reads or writes whichever of four 16-bit registers the pointer selects.

Register 0 is the command and status word. The host issues commands by writing ones to the command bits: initialize, start, stop and transmit demand. It clears latched status by writing ones to the status bits. The error summary and interrupt summary bits are computed from the stored status and are never stored themselves. Register 1 and register 2 together hold the 24-bit base address of the initialization block, which is passed to the init engine. Register 3 holds a 3-bit bus configuration.

The transmit, receive and init engines report events through single-cycle set inputs. The block drives single-cycle command pulses and a transmit-poll enable back to them. The interrupt output follows the interrupt summary bit.

Top module: `lan_csr_port`

## Requirements
- R1: On reset, register 0 reads 0x0004 (stop bit 2 only), registers 1 to 3 and the pointer read 0, and `irq` is low.
- R2: A write with `host_sel`=1 loads the pointer with `host_wdata[1:0]`. A read with `host_sel`=1 returns the pointer zero-extended. A read with `host_sel`=0 returns the register the pointer selects.
- R3: Register 1 stores the written data with bit 0 forced to 0. Register 2 keeps only bits 7:0. Register 3 keeps only bits 2:0. `init_base` is {register 2[7:0], register 1} and `bus_cfg` is register 3[2:0].
- R4: In register 0, writing 1 to any of bits 14:8 (bits 14..11 errors, 10 receive done, 9 transmit done, 8 init done) clears that bit, and writing 0 leaves it unchanged. Bit 15 reads as the OR of bits 14:11. Writes to bits 15, 7 and 6 have no effect, and bit 6 always reads 0.
- R5: Bit 7 of register 0 reads as the OR of bits 14:8, and `irq` equals bit 7.
- R6: Writing 1 to bit 2 clears bits 0, 1, 4, 5 and 8, sets bit 2 and zeroes register 3. Any init, start or demand bits written in the same word are ignored and produce no pulse.
- R7: Writing 1 to bit 0 (without bit 2) clears bit 2 and sets bits 0, 4 (transmit on) and 5 (receive on). It also raises `init_go` for exactly one cycle, in the cycle after the write.
- R8: Writing 1 to bit 1 (without bit 2) clears bit 2, sets bit 1 and raises `strt_go` for one cycle. In that write, `rx_off` clears bit 5 and `tx_off` clears bit 4. These clears are applied after any init written in the same word. `poll_en` is high while bit 1 and bit 4 are set and bit 2 is clear.
- R9: Writing 1 to bit 3 (without bit 2) raises `tdmd_go` for one cycle. Bit 3 always reads 0.
- R10: `set_idon`, `set_tint`, `set_rint` and `set_err[3:0]` (mapping to bits 11..14) set their status bits. A set wins over a clear written in the same cycle.
- R11: A `tx_fault` pulse clears bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | 1 selects the pointer, 0 selects the data port |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for the current `host_sel` |
| rx_off | input | 1 | Mode: receiver disabled on start |
| tx_off | input | 1 | Mode: transmitter disabled on start |
| set_idon | input | 1 | Init engine done pulse |
| set_tint | input | 1 | Transmit done pulse |
| set_rint | input | 1 | Receive done pulse |
| set_err | input | 4 | Error set pulses for bits 11..14 |
| tx_fault | input | 1 | Transmit engine drops transmit-on |
| irq | output | 1 | Interrupt request |
| init_go | output | 1 | One-cycle init command |
| strt_go | output | 1 | One-cycle start command |
| tdmd_go | output | 1 | One-cycle transmit demand |
| poll_en | output | 1 | Transmit poller enable |
| init_base | output | 24 | Init block base address |
| bus_cfg | output | 3 | Bus configuration bits |

## Verification
The bench compares a behavioural model against every output in every cycle across these stimuli:
- Pointer writes with high data bits set, which separate masking from full storage.
- Writes of all ones to registers 1 to 3, which expose each register's kept-bit mask.
- Stop written together with init, start and demand, which shows whether stop really overrides them.
- Init and start written in one word with the disable inputs high, which tests the order in which transmit-on and receive-on are settled.
- Engine set pulses landing in the same cycle as a host clear, which decides the set-over-clear priority.
- Writes of ones to the summary and reserved bits, which must leave the register unchanged.

// File: rtl/lan_csr_port.sv
`timescale 1ns/1ps
module lan_csr_port #(
  parameter int DW   = 16,
  parameter int PW   = 2,
  parameter int NERR = 4,
  parameter int C3W  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          rx_off,
  input  logic          tx_off,
  input  logic          set_idon,
  input  logic          set_tint,
  input  logic          set_rint,
  input  logic [NERR-1:0] set_err,
  input  logic          tx_fault,
  output logic          irq,
  output logic          init_go,
  output logic          strt_go,
  output logic          tdmd_go,
  output logic          poll_en,
  output logic [DW+7:0] init_base,
  output logic [C3W-1:0] bus_cfg
);
  localparam int B_INIT = 0, B_STRT = 1, B_STOP = 2, B_TDMD = 3, B_TXON = 4, B_RXON = 5;
  localparam int B_IDON = 8, B_TINT = 9, B_RINT = 10, B_ERR0 = 11;

  logic [PW-1:0]   rap;
  logic [DW-1:0]   reg1;
  logic [7:0]      reg2;
  logic [C3W-1:0]  reg3;
  logic st_init, st_strt, st_stop, st_txon, st_rxon, st_idon, st_tint, st_rint;
  logic [NERR-1:0] st_err;

  logic          wr0, wr_data;
  logic [DW-1:0] cmd;
  logic          stop_cmd, err_any, intr;
  logic [DW-1:0] csr0;

  assign wr_data  = host_wr & ~host_sel;
  assign wr0      = wr_data & (rap == '0);
  assign cmd      = wr0 ? host_wdata : '0;
  assign stop_cmd = cmd[B_STOP];

  assign err_any = |st_err;
  assign intr    = err_any | st_idon | st_tint | st_rint;
  assign csr0    = {err_any, st_err, st_rint, st_tint, st_idon, intr, 1'b0,
                    st_rxon, st_txon, 1'b0, st_stop, st_strt, st_init};

  always_comb begin
    host_rdata = '0;
    if (host_sel) host_rdata[PW-1:0] = rap;
    else begin
      case (rap)
        2'd0:    host_rdata = csr0;
        2'd1:    host_rdata = reg1;
        2'd2:    host_rdata[7:0] = reg2;
        default: host_rdata[C3W-1:0] = reg3;
      endcase
    end
  end

  assign irq       = intr;
  assign poll_en   = st_strt & st_txon & ~st_stop;
  assign init_base = {reg2, reg1};
  assign bus_cfg   = reg3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rap  <= '0;
      reg1 <= '0;
      reg2 <= '0;
      reg3 <= '0;
    end else begin
      if (host_wr && host_sel) rap <= host_wdata[PW-1:0];
      if (wr_data && rap == 2'd1) reg1 <= {host_wdata[DW-1:1], 1'b0};
      if (wr_data && rap == 2'd2) reg2 <= host_wdata[7:0];
      if (wr_data && rap == 2'd3) reg3 <= host_wdata[C3W-1:0];
      if (stop_cmd) reg3 <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_init <= 1'b0;
      st_strt <= 1'b0;
      st_stop <= 1'b1;
      st_txon <= 1'b0;
      st_rxon <= 1'b0;
      init_go <= 1'b0;
      strt_go <= 1'b0;
      tdmd_go <= 1'b0;
    end else begin
      init_go <= cmd[B_INIT] & ~stop_cmd;
      strt_go <= cmd[B_STRT] & ~stop_cmd;
      tdmd_go <= cmd[B_TDMD] & ~stop_cmd;
      if (tx_fault) st_txon <= 1'b0;
      if (stop_cmd) begin
        st_init <= 1'b0;
        st_strt <= 1'b0;
        st_stop <= 1'b1;
        st_txon <= 1'b0;
        st_rxon <= 1'b0;
      end else begin
        if (cmd[B_INIT]) begin
          st_stop <= 1'b0;
          st_init <= 1'b1;
          st_txon <= 1'b1;
          st_rxon <= 1'b1;
        end
        if (cmd[B_STRT]) begin
          st_stop <= 1'b0;
          st_strt <= 1'b1;
          if (rx_off) st_rxon <= 1'b0;
          if (tx_off) st_txon <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_idon <= 1'b0;
      st_tint <= 1'b0;
      st_rint <= 1'b0;
      st_err  <= '0;
    end else begin
      st_idon <= (st_idon & ~cmd[B_IDON] & ~stop_cmd) | set_idon;
      st_tint <= (st_tint & ~cmd[B_TINT]) | set_tint;
      st_rint <= (st_rint & ~cmd[B_RINT]) | set_rint;
      st_err  <= (st_err & ~cmd[B_ERR0 +: NERR]) | set_err;
    end
  end

  // R6
  stop_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && host_wdata[B_STOP]) |=> (st_stop && !st_init && !st_strt && !init_go && !strt_go && !tdmd_go && reg3 == '0));
  // R7
  init_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_go |-> (st_init && !st_stop));
  // R8
  strt_txoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && host_wdata[B_STRT] && !host_wdata[B_STOP] && tx_off) |=> (!st_txon && !poll_en && strt_go));
  // R10
  tint_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_tint |=> st_tint);
  // R4
  tint_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && host_wdata[B_TINT] && !set_tint) |=> !st_tint);
endmodule

// File: tb/lan_csr_port_bench.sv
`timescale 1ns/1ps
module lan_csr_port_bench;
  logic clk = 0, rst_n = 0;
  logic hsel = 0, hwr = 0;
  logic [15:0] hwd = 0;
  logic rx_off = 0, tx_off = 0, s_idon = 0, s_tint = 0, s_rint = 0, tx_fault = 0;
  logic [3:0] s_err = 0;
  logic [15:0] rdata;
  logic irq, init_go, strt_go, tdmd_go, poll_en;
  logic [23:0] init_base;
  logic [2:0] bus_cfg;

  always #2 clk = ~clk;

  lan_csr_port u_lan_csr_port (
    .clk(clk), .rst_n(rst_n), .host_sel(hsel), .host_wr(hwr), .host_wdata(hwd),
    .host_rdata(rdata), .rx_off(rx_off), .tx_off(tx_off), .set_idon(s_idon),
    .set_tint(s_tint), .set_rint(s_rint), .set_err(s_err), .tx_fault(tx_fault),
    .irq(irq), .init_go(init_go), .strt_go(strt_go), .tdmd_go(tdmd_go),
    .poll_en(poll_en), .init_base(init_base), .bus_cfg(bus_cfg));

  int checks = 0, fails = 0;
  string req = "R1";
  bit done = 0;

  // model state
  int m_st, m_rap, m_r1, m_r2, m_r3;
  bit m_ig, m_sg, m_tg;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 16'h0004; m_rap = 0; m_r1 = 0; m_r2 = 0; m_r3 = 0;
      m_ig = 0; m_sg = 0; m_tg = 0;
    end else begin
      int w;
      w = (hwr && !hsel && m_rap == 0) ? int'(hwd) : 0;
      if (hwr && !hsel) begin
        if (m_rap == 1) m_r1 = hwd & 16'hFFFE;
        if (m_rap == 2) m_r2 = hwd & 16'h00FF;
        if (m_rap == 3) m_r3 = hwd & 16'h0007;
      end
      if (hwr && hsel) m_rap = hwd & 3;
      m_st = m_st & ~(w & 16'h7F00);
      if (tx_fault) m_st = m_st & ~16'h0010;
      m_ig = 0; m_sg = 0; m_tg = 0;
      if (w & 4) begin
        m_st = (m_st & ~16'h0133) | 16'h0004;
        m_r3 = 0;
      end else begin
        if (w & 1) begin m_st = (m_st & ~4) | 16'h0031; m_ig = 1; end
        if (w & 2) begin
          m_st = (m_st & ~4) | 2; m_sg = 1;
          if (rx_off) m_st = m_st & ~16'h0020;
          if (tx_off) m_st = m_st & ~16'h0010;
        end
        if (w & 8) m_tg = 1;
      end
      m_st = m_st | (int'(s_idon) << 8) | (int'(s_tint) << 9) | (int'(s_rint) << 10) | (int'(s_err) << 11);
    end
  end

  function automatic int exp_read();
    int v;
    if (hsel) return m_rap;
    case (m_rap)
      0: begin
        v = m_st;
        if (v & 16'h7800) v = v | 16'h8000;
        if (v & 16'h7F00) v = v | 16'h0080;
        return v;
      end
      1: return m_r1;
      2: return m_r2;
      default: return m_r3;
    endcase
  endfunction

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", r, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e;
      e = exp_read();
      chk(req, "rdata", rdata, e);
      chk(req, "irq", irq, (m_st & 16'h7F00) != 0);
      chk(req, "init_go", init_go, m_ig);
      chk(req, "strt_go", strt_go, m_sg);
      chk(req, "tdmd_go", tdmd_go, m_tg);
      chk(req, "poll_en", poll_en, ((m_st & 2) != 0) && ((m_st & 16'h10) != 0) && ((m_st & 4) == 0));
      chk(req, "init_base", init_base, (m_r2 << 16) | m_r1);
      chk(req, "bus_cfg", bus_cfg, m_r3);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask
  task automatic hw(bit s, logic [15:0] d);
    hsel = s; hwr = 1; hwd = d;
    @(negedge clk); #1; hwr = 0;
  endtask
  task automatic sets(bit i, bit t, bit r, logic [3:0] e);
    s_idon = i; s_tint = t; s_rint = r; s_err = e;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #40000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    @(negedge clk); #1; rst_n = 1;
    req = "R1"; idle(2);
    hsel = 1; idle(2);
    // R2: pointer masking and readback
    req = "R2";
    hw(1, 16'hFFF7); idle(2);
    hw(1, 16'h0005); idle(2);
    // R3: register masks
    req = "R3";
    hw(0, 16'hFFFF); hsel = 0; idle(2);
    hw(1, 2); hw(0, 16'hFFFF); hsel = 0; idle(2);
    hw(1, 3); hw(0, 16'hFFFF); hsel = 0; idle(2);
    hw(1, 0); hsel = 0; idle(1);
    // R7: init command
    req = "R7";
    hw(0, 16'h0001); idle(3);
    // R8: start with receive disabled
    req = "R8";
    rx_off = 1; hw(0, 16'h0002); rx_off = 0; idle(3);
    // R9: transmit demand
    req = "R9";
    hw(0, 16'h0008); idle(2);
    // R10: engine sets, and set beating a same-cycle clear
    req = "R10";
    sets(1, 1, 0, 4'b0101); idle(1); sets(0, 0, 0, 0); idle(2);
    sets(0, 1, 1, 4'b0001); hw(0, 16'h7F00); sets(0, 0, 0, 0); idle(2);
    // R4: single clears and ignored summary bits
    req = "R4";
    hw(0, 16'h0200); idle(1);
    hw(0, 16'h80C0); idle(1);
    hw(0, 16'h0800); idle(1);
    // R5: interrupt follows the remaining sources, then drops
    req = "R5";
    hw(0, 16'h7F00); idle(2);
    sets(0, 0, 1, 0); idle(1); sets(0, 0, 0, 0); idle(1);
    hw(0, 16'h0400); idle(2);
    // R11: transmit fault
    req = "R11";
    tx_fault = 1; idle(1); tx_fault = 0; idle(2);
    // R6: stop overrides init/start/demand and zeroes register 3
    req = "R6";
    hw(1, 3); hw(0, 16'h0005); hw(1, 0); hsel = 0;
    hw(0, 16'h0001); sets(1, 0, 0, 0); idle(1); sets(0, 0, 0, 0);
    hw(0, 16'h000F); idle(2);
    hw(1, 3); hsel = 0; idle(1); hw(1, 0); hsel = 0;
    // R8: init and start together with transmit disabled
    req = "R8";
    tx_off = 1; hw(0, 16'h0003); tx_off = 0; idle(2);
    hw(0, 16'h0002); idle(2);
    // R10: set during a stop write
    req = "R10";
    sets(1, 0, 0, 0); hw(0, 16'h0004); sets(0, 0, 0, 0); idle(2);
    idle(2);
    finish_run();
  end
endmodule